// File: doc/BRIEF.md
# Two-Way Data Cache with Line Locking

This block is a data cache between one processor-side request port and a memory-side port. The memory side has two halves: a line fetch path that streams a whole line in, and a write buffer that drains stores and evicted lines one 64-bit word at a time. The cache has two ways per set, 64-byte lines and 64-bit accesses. A hit is answered one cycle after it is accepted. A miss fetches the line and then replays the same request, which now hits.

When a line must be replaced, the victim is the way that was filled longest ago. Hits do not change this choice. Any line can be pinned with a lock flag so that it is never replaced. If both ways of a set are pinned, a miss is served straight from memory and no line is allocated. A mode input picks the store policy. In write-back mode, stores only mark the line dirty, and a dirty victim is copied into the buffer before the new line is fetched. In write-through mode, every store also enters the buffer.

The set count, the widths and the buffer depth are parameters. The test configuration uses 16 sets and a 16-entry buffer.

Top module: `cache2w_lock`

## Requirements
- R1: A request that hits is accepted (req_ready high) in the cycle it is presented. rsp_valid is high exactly one cycle after every accepted request, and never otherwise. For a read, rsp_rdata then holds the addressed word.
- R2: Address bits [5:3] select the word in a line, the next log2(SETS) bits select the set, and the remaining upper bits form the tag. A miss holds mem_rd_req with a line-aligned mem_rd_addr, and takes exactly 8 beats on mem_rd_valid, lowest word first.
- R3: If both ways of a set are valid and unlocked, a miss replaces the way that was filled earlier, whatever hits have touched since.
- R4: An accepted hit with req_lock set pins its line, and one with req_unlock set unpins it. A pinned line is never chosen as victim, so it keeps hitting while misses to its set go elsewhere.
- R5: If both ways of the set are pinned, a read miss fetches the line and returns the word without storing it, so a repeat of that read misses again. A write miss is accepted with hit timing as a single buffer entry.
- R6: In write-back mode (wt_mode=0), a write hit updates the line and produces no buffer traffic. Replacing a dirty line pushes its 8 words into the buffer. A line fetch starts only once the buffer is empty.
- R7: In write-through mode (wt_mode=1), a write hit updates the line and pushes exactly one buffer entry, and the line stays clean, so replacing it later pushes nothing.
- R8: The buffer holds at most 16 entries. While it is full, a request that needs a slot is held with req_ready low, and it is accepted once a slot frees.
- R9: After reset, rsp_valid, wb_valid and mem_rd_req are low, and every line is invalid.
- R10: Buffer entries drain oldest first at word-aligned addresses. Every read returns the value of the most recent write to that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wt_mode | input | 1 | 1 selects write-through, 0 selects write-back |
| req_valid | input | 1 | Request present; held until accepted |
| req_write | input | 1 | 1 for a store |
| req_lock | input | 1 | Pin the addressed line on this access |
| req_unlock | input | 1 | Unpin the addressed line on this access |
| req_addr | input | AW | Byte address |
| req_wdata | input | DW | Store data |
| req_ready | output | 1 | Request accepted this cycle |
| rsp_valid | output | 1 | Response cycle |
| rsp_rdata | output | DW | Read data |
| mem_rd_req | output | 1 | Line fetch in progress |
| mem_rd_addr | output | AW | Line-aligned fetch address |
| mem_rd_valid | input | 1 | Fetch beat present |
| mem_rd_data | input | DW | Fetch beat data |
| wb_valid | output | 1 | Buffer head present |
| wb_addr | output | AW | Buffer head address |
| wb_data | output | DW | Buffer head data |
| wb_ready | input | 1 | Memory takes the buffer head |

## Verification
Each access is driven at a falling edge and held. The bench then counts falling edges until rsp_valid appears. A hit, a pinned-set store and a write-through store must answer at the first falling edge, one registered stage after acceptance. A miss answers later, after the 8 fetch beats and the replay. This count is how each table entry and directed test tells a hit from a miss, which exposes both the victim choice and the effect of the lock flags. Buffer traffic is counted at the edges where the memory model takes an entry, and it is compared only after enough idle cycles for the drain to settle. The stall test samples req_ready and rsp_valid at falling edges over several blocked cycles.

// File: rtl/cache2w_lock.sv
module cache2w_lock #(
  parameter int AW         = 32,
  parameter int DW         = 64,
  parameter int LINE_BYTES = 64,
  parameter int SETS       = 16,
  parameter int WB_DEPTH   = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wt_mode,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_lock,
  input  logic          req_unlock,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          mem_rd_req,
  output logic [AW-1:0] mem_rd_addr,
  input  logic          mem_rd_valid,
  input  logic [DW-1:0] mem_rd_data,
  output logic          wb_valid,
  output logic [AW-1:0] wb_addr,
  output logic [DW-1:0] wb_data,
  input  logic          wb_ready
);
  localparam int BEATS = LINE_BYTES * 8 / DW;
  localparam int BOFF  = $clog2(DW / 8);
  localparam int WOFF  = $clog2(BEATS);
  localparam int LOFF  = BOFF + WOFF;
  localparam int IDXW  = $clog2(SETS);
  localparam int TAGW  = AW - LOFF - IDXW;
  localparam int WBW   = $clog2(WB_DEPTH);
  localparam int LINES = SETS * BEATS;
  localparam int QAW   = AW - BOFF;

  typedef enum logic [2:0] {S_IDLE, S_EVICT, S_DRAIN, S_FILL, S_BYP} st_t;
  st_t st;

  logic [SETS-1:0] vld [2];
  logic [SETS-1:0] drt [2];
  logic [SETS-1:0] lck [2];
  logic [SETS-1:0] lrf;
  logic [TAGW-1:0] tagq [2][SETS];
  logic [DW-1:0]   dat  [2][LINES];

  logic [IDXW-1:0] idx;
  logic [TAGW-1:0] tag;
  logic [WOFF-1:0] wsel;
  logic            unused_lsb;
  assign idx        = req_addr[LOFF +: IDXW];
  assign tag        = req_addr[AW-1 -: TAGW];
  assign wsel       = req_addr[BOFF +: WOFF];
  assign unused_lsb = ^req_addr[BOFF-1:0];

  logic hit0, hit1, hit, hway, both_lck;
  assign hit0     = vld[0][idx] && (tagq[0][idx] == tag);
  assign hit1     = vld[1][idx] && (tagq[1][idx] == tag);
  assign hit      = hit0 | hit1;
  assign hway     = hit1;
  assign both_lck = lck[0][idx] & lck[1][idx];

  logic vway;
  always_comb begin
    if (!vld[0][idx])      vway = 1'b0;
    else if (!vld[1][idx]) vway = 1'b1;
    else if (lck[0][idx])  vway = 1'b1;
    else if (lck[1][idx])  vway = 1'b0;
    else                   vway = lrf[idx];
  end

  logic            m_way, m_byp;
  logic [IDXW-1:0] m_idx;
  logic [TAGW-1:0] m_tag;
  logic [WOFF-1:0] m_wsel, beat;
  logic [DW-1:0]   cap;

  logic [QAW-1:0]  wbq_a [WB_DEPTH];
  logic [DW-1:0]   wbq_d [WB_DEPTH];
  logic [WBW-1:0]  wr_p, rd_p;
  logic [WBW:0]    wb_cnt;
  logic            wb_full, wb_empty;
  assign wb_full  = wb_cnt == (WBW+1)'(WB_DEPTH);
  assign wb_empty = wb_cnt == '0;

  logic is_idle, accept, acc_hit, acc_bw, miss_go, ev_push, push, pop, fill_beat, fill_last;
  assign is_idle = st == S_IDLE;
  assign req_ready = (is_idle && (hit ? !(req_write && wt_mode && wb_full)
                                      : (both_lck && req_write && !wb_full)))
                     || st == S_BYP;
  assign accept    = req_valid && req_ready;
  assign acc_hit   = accept && is_idle && hit;
  assign acc_bw    = accept && is_idle && !hit;
  assign miss_go   = is_idle && req_valid && !hit && !(both_lck && req_write);
  assign ev_push   = st == S_EVICT && !wb_full;
  assign push      = (acc_hit && req_write && wt_mode) || acc_bw || ev_push;
  assign pop       = wb_valid && wb_ready;
  assign fill_beat = st == S_FILL && mem_rd_valid;
  assign fill_last = fill_beat && beat == WOFF'(BEATS - 1);

  logic [QAW-1:0] push_a;
  logic [DW-1:0]  push_d;
  assign push_a = ev_push ? {tagq[m_way][m_idx], m_idx, beat} : req_addr[AW-1:BOFF];
  assign push_d = ev_push ? dat[m_way][{m_idx, beat}] : req_wdata;

  assign mem_rd_req  = st == S_FILL;
  assign mem_rd_addr = {m_tag, m_idx, {LOFF{1'b0}}};
  assign wb_valid    = !wb_empty;
  assign wb_addr     = {wbq_a[rd_p], {BOFF{1'b0}}};
  assign wb_data     = wbq_d[rd_p];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      m_way <= 1'b0; m_byp <= 1'b0; m_idx <= '0; m_tag <= '0; m_wsel <= '0;
      beat <= '0; cap <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (miss_go) begin
          m_tag <= tag; m_idx <= idx; m_wsel <= wsel; m_byp <= both_lck;
          m_way <= vway; beat <= '0;
          st <= (!both_lck && vld[vway][idx] && drt[vway][idx]) ? S_EVICT : S_DRAIN;
        end
        S_EVICT: if (ev_push) begin
          beat <= beat + 1'b1;
          if (beat == WOFF'(BEATS - 1)) st <= S_DRAIN;
        end
        S_DRAIN: if (wb_empty) st <= S_FILL;
        S_FILL: if (mem_rd_valid) begin
          beat <= beat + 1'b1;
          if (m_byp && beat == m_wsel) cap <= mem_rd_data;
          if (fill_last) st <= m_byp ? S_BYP : S_IDLE;
        end
        S_BYP: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld[0] <= '0; vld[1] <= '0;
      drt[0] <= '0; drt[1] <= '0;
      lck[0] <= '0; lck[1] <= '0;
      lrf <= '0;
    end else begin
      if (acc_hit) begin
        if (req_write && !wt_mode) drt[hway][idx] <= 1'b1;
        if (req_lock)        lck[hway][idx] <= 1'b1;
        else if (req_unlock) lck[hway][idx] <= 1'b0;
      end
      if (st == S_DRAIN && wb_empty && !m_byp) begin
        vld[m_way][m_idx] <= 1'b0;
        drt[m_way][m_idx] <= 1'b0;
        lck[m_way][m_idx] <= 1'b0;
      end
      if (fill_last && !m_byp) begin
        vld[m_way][m_idx] <= 1'b1;
        lrf[m_idx]        <= ~m_way;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (acc_hit && req_write) dat[hway][{idx, wsel}] <= req_wdata;
    if (fill_beat && !m_byp)  dat[m_way][{m_idx, beat}] <= mem_rd_data;
    if (fill_last && !m_byp)  tagq[m_way][m_idx] <= m_tag;
    if (push) begin
      wbq_a[wr_p] <= push_a;
      wbq_d[wr_p] <= push_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_p <= '0; rd_p <= '0; wb_cnt <= '0;
      rsp_valid <= 1'b0; rsp_rdata <= '0;
    end else begin
      if (push) wr_p <= (wr_p == WBW'(WB_DEPTH - 1)) ? '0 : wr_p + 1'b1;
      if (pop)  rd_p <= (rd_p == WBW'(WB_DEPTH - 1)) ? '0 : rd_p + 1'b1;
      wb_cnt <= wb_cnt + (WBW+1)'(push) - (WBW+1)'(pop);
      rsp_valid <= accept;
      if (accept) rsp_rdata <= (st == S_BYP) ? cap : dat[hway][{idx, wsel}];
    end
  end

  p_rsp_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);
  p_no_stray_rsp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !rsp_valid);
  p_fetch_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_rd_valid) |=> mem_rd_req);
  p_victim_unpinned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DRAIN && !m_byp) |-> !lck[m_way][m_idx]);
  p_bypass_no_alloc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && m_byp) |=> ($stable(vld[0]) && $stable(vld[1])));
  p_fetch_after_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_rd_req) |-> wb_empty);
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_cnt <= (WBW+1)'(WB_DEPTH));
  p_full_blocks_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_full && !pop) |=> wb_full || !wb_valid || wb_cnt == (WBW+1)'(WB_DEPTH - 1));
endmodule

// File: tb/cache2w_lock_tb.sv
`timescale 1ns/1ps
module cache2w_lock_tb;
  logic clk = 1'b0, rst_n = 1'b0, wt_mode = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_lock = 1'b0, req_unlock = 1'b0;
  logic [31:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic req_ready, rsp_valid, mem_rd_req, wb_valid;
  logic [63:0] rsp_rdata, wb_data, mem_rd_data;
  logic [31:0] mem_rd_addr, wb_addr;
  logic mem_rd_valid;
  logic wb_ready = 1'b1;

  always #2.5 clk = ~clk;

  cache2w_lock u_dut (
    .clk(clk), .rst_n(rst_n), .wt_mode(wt_mode),
    .req_valid(req_valid), .req_write(req_write), .req_lock(req_lock), .req_unlock(req_unlock),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
    .mem_rd_data(mem_rd_data), .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data),
    .wb_ready(wb_ready)
  );

  function automatic logic [63:0] init_word(input int i);
    return {16'hC0DE, 16'(i), 32'(i * 3 + 1)};
  endfunction

  logic [63:0] mem  [2048];
  logic [63:0] gold [2048];
  logic [2047:0] touched;
  int drains, misaligned, fcnt;

  function automatic logic [63:0] mem_rd(input int i);
    return touched[i] ? mem[i] : init_word(i);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      touched <= '0; drains <= 0; misaligned <= 0;
    end else begin
      if (wb_valid && wb_ready) begin
        mem[wb_addr[13:3]] <= wb_data;
        touched[wb_addr[13:3]] <= 1'b1;
        drains <= drains + 1;
        if (wb_addr[2:0] != 3'b0) misaligned <= misaligned + 1;
      end
      if (mem_rd_req && mem_rd_addr[5:0] != 6'b0) misaligned <= misaligned + 1;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      fcnt <= 0; mem_rd_valid <= 1'b0; mem_rd_data <= '0;
    end else if (mem_rd_req && fcnt < 8) begin
      mem_rd_valid <= 1'b1;
      mem_rd_data  <= mem_rd(int'(mem_rd_addr[13:3]) + fcnt);
      fcnt <= fcnt + 1;
    end else begin
      mem_rd_valid <= 1'b0;
      if (!mem_rd_req) fcnt <= 0;
    end
  end

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic lk, input logic ul, input logic [15:0] a,
                        input logic [63:0] d, output int lat, output logic [63:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_lock = lk; req_unlock = ul;
    req_addr = 32'(a); req_wdata = d;
    if (wr) gold[a[13:3]] = d;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!rsp_valid && lat < 500);
    rd = rsp_rdata;
    req_valid = 1'b0; req_write = 1'b0; req_lock = 1'b0; req_unlock = 1'b0;
  endtask

  task automatic rd_chk(input logic [15:0] a, input bit exp_hit, input string rq);
    int lat; logic [63:0] rd;
    access(1'b0, 1'b0, 1'b0, a, '0, lat, rd);
    chk((lat == 1) == exp_hit, rq, 64'(lat), exp_hit ? 64'd1 : 64'd99);
    chk(rd == gold[a[13:3]], "R10 read data", rd, gold[a[13:3]]);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // {expect_hit, write, addr}; set 0 lines at 0x0000/0x0400/0x0800, set 1 at 0x0040
  localparam logic [17:0] VEC [14] = '{
    {1'b0, 1'b0, 16'h0008}, {1'b1, 1'b0, 16'h0010}, {1'b0, 1'b0, 16'h0400},
    {1'b1, 1'b0, 16'h0000}, {1'b1, 1'b1, 16'h0018}, {1'b0, 1'b0, 16'h0820},
    {1'b1, 1'b0, 16'h0408}, {1'b0, 1'b0, 16'h0018}, {1'b1, 1'b0, 16'h0820},
    {1'b0, 1'b0, 16'h0040}, {1'b1, 1'b1, 16'h0048}, {1'b1, 1'b0, 16'h0048},
    {1'b0, 1'b0, 16'h0400}, {1'b1, 1'b0, 16'h0018}
  };

  initial begin
    int lat, d0;
    logic [63:0] rd;
    for (int i = 0; i < 2048; i++) gold[i] = init_word(i);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rsp_valid && !wb_valid && !mem_rd_req, "R9 reset outputs", {rsp_valid, wb_valid, mem_rd_req}, 0);

    // R1 R2 R3 R6 R9 R10: table walk in write-back mode; entry 6 hits only under fill-order replacement (R3)
    for (int i = 0; i < 14; i++) begin
      access(VEC[i][16], 1'b0, 1'b0, VEC[i][15:0], {16'hBEEF, 16'(i), 16'h0, VEC[i][15:0]}, lat, rd);
      chk((lat == 1) == VEC[i][17], "R1/R3 hit-or-miss timing", 64'(lat), VEC[i][17] ? 64'd1 : 64'd99);
      if (!VEC[i][16]) chk(rd == gold[VEC[i][13:3]], "R10 read data", rd, gold[VEC[i][13:3]]);
    end

    // R4 R5: pin both lines of set 0 (B way0, A way1)
    access(1'b0, 1'b1, 1'b0, 16'h0000, '0, lat, rd);
    chk(lat == 1, "R4 lock on hit", 64'(lat), 1);
    access(1'b0, 1'b1, 1'b0, 16'h0400, '0, lat, rd);
    rd_chk(16'h0810, 1'b0, "R5 pinned set read misses");
    rd_chk(16'h0810, 1'b0, "R5 no allocation on pinned set");
    rd_chk(16'h0000, 1'b1, "R4 pinned line kept");
    rd_chk(16'h0400, 1'b1, "R4 pinned line kept");
    access(1'b1, 1'b0, 1'b0, 16'h0C08, 64'h5A5A_0000_0C08_0001, lat, rd);
    chk(lat == 1, "R5 pinned set write accepted at hit timing", 64'(lat), 1);
    rd_chk(16'h0C08, 1'b0, "R5 bypass write reaches memory");
    access(1'b0, 1'b0, 1'b1, 16'h0000, '0, lat, rd);
    rd_chk(16'h0C08, 1'b0, "R4 unpinned way refilled");
    rd_chk(16'h0C08, 1'b1, "R4 refilled line hits");
    rd_chk(16'h0400, 1'b1, "R4 still pinned line kept");
    rd_chk(16'h0000, 1'b0, "R4 unpinned line replaced");

    // R6: write-back store hit, then dirty eviction
    idle(20); d0 = drains;
    access(1'b1, 1'b0, 1'b0, 16'h0048, 64'h1111_2222_3333_0048, lat, rd);
    idle(20);
    chk(drains == d0, "R6 write-back store silent", 64'(drains - d0), 0);
    rd_chk(16'h0440, 1'b0, "R6 fill of empty way");
    idle(5); d0 = drains;
    rd_chk(16'h0840, 1'b0, "R6 miss replacing dirty line");
    idle(20);
    chk(drains - d0 == 8, "R6 dirty victim pushes 8 words", 64'(drains - d0), 8);
    rd_chk(16'h0048, 1'b0, "R6 written-back data reloaded");

    // R7: write-through
    wt_mode = 1'b1; idle(2); d0 = drains;
    access(1'b1, 1'b0, 1'b0, 16'h0848, 64'h7777_0000_0848_0007, lat, rd);
    chk(lat == 1, "R7 write-through hit timing", 64'(lat), 1);
    idle(20);
    chk(drains - d0 == 1, "R7 one buffer entry per store", 64'(drains - d0), 1);
    rd_chk(16'h0848, 1'b1, "R7 line updated");
    d0 = drains;
    rd_chk(16'h0C40, 1'b0, "R7 replace clean line");
    idle(20);
    chk(drains == d0, "R7 clean victim pushes nothing", 64'(drains - d0), 0);

    // R8: fill the buffer, then one store too many
    wb_ready = 1'b0; d0 = drains;
    for (int i = 0; i < 16; i++) begin
      access(1'b1, 1'b0, 1'b0, 16'(16'h0C40 + (i % 8) * 8), 64'(64'hF000 + i), lat, rd);
      chk(lat == 1, "R8 store accepted while slots free", 64'(lat), 1);
    end
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 32'h0C50; req_wdata = 64'hFACE;
    gold[16'h0C50 >> 3] = 64'hFACE;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(!req_ready && !rsp_valid, "R8 store held while full", {req_ready, rsp_valid}, 0);
    end
    wb_ready = 1'b1;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!rsp_valid && lat < 50);
    req_valid = 1'b0; req_write = 1'b0;
    chk(rsp_valid, "R8 store completes after drain", 64'(rsp_valid), 1);
    idle(40);
    chk(drains - d0 == 17, "R8 all entries drained", 64'(drains - d0), 17);
    rd_chk(16'h0C50, 1'b1, "R8 data after stall");
    rd_chk(16'h0C78, 1'b1, "R8 data after stall");
    chk(misaligned == 0, "R2 aligned fetch and drain addresses", 64'(misaligned), 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule